// File: doc/BRIEF.md
# Double-Entry Password Update Controller

This block runs the sequence that replaces one of three stored 64-bit passwords (read, write or configuration). A start strobe opens a frame. The first byte is a command. The next eight bytes must reproduce the password that is stored now, most significant byte first. For a change command, the host then sends the new password twice, eight bytes each time. The block acknowledges every byte it accepts. It only commits the new value when the two entries agree, and it checks this after the last byte of the second entry. A second command skips the new entries and sets the selected password to all zeros once the old password has been verified.

Any failure sends the block to standby without an acknowledge. Failures are an unknown command, a wrong old-password byte, or a mismatch between the two entries. In standby every byte is ignored until the next start strobe. A commit raises a one-cycle write request that carries the new value and the target, and sets a busy flag. Busy stays high until the storage array signals completion. While busy, bytes receive no acknowledge, so the host can detect completion by polling. Nothing in the block can return a stored password.

Top module: `pwd_update_ctrl`

## Requirements
- R1: After reset, `ack`, `wr_req` and `busy` are low. A byte that arrives before any start strobe gets no acknowledge.
- R2: After a start strobe, the first byte is accepted and acknowledged only if it is 0x5A (change) or 0xA5 (clear) and `tgt_sel` is 0 (read), 1 (write) or 2 (configuration). Any other byte, or `tgt_sel` = 3, gets no acknowledge and sends the block to standby.
- R3: Old-password byte i (i = 0..7) is compared with `old_pwd[63-8i -: 8]`, so the most significant byte comes first. A match is acknowledged. On a mismatch that byte and all later bytes of the frame get no acknowledge, and no write request is issued.
- R4: For a change command, all eight bytes of the first new entry and the first seven bytes of the second entry are acknowledged, whatever their values.
- R5: If the two new entries differ in any byte, the eighth byte of the second entry gets no acknowledge. No write request is issued, and later bytes are ignored until a start strobe.
- R6: If the two entries are equal, the eighth byte of the second entry is acknowledged. In that same cycle `wr_req` pulses for exactly one cycle, `wr_data` holds the new password and `wr_tgt` holds the value that `tgt_sel` had at the command byte.
- R7: For a clear command, the eighth matching old-password byte is acknowledged. In that same cycle a write request is issued with `wr_data` equal to zero.
- R8: `busy` rises together with `wr_req` and stays high until the cycle after `wr_done`. While busy, bytes are not acknowledged and start strobes are ignored. After busy falls, the block waits for a new start strobe.
- R9: A start strobe in the middle of a frame drops the partial sequence. The next byte is treated as a new command.
- R10: `ack` rises in the cycle after the byte's valid cycle and lasts one cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| start | input | 1 | Frame-open strobe (bus start condition) |
| byte_valid | input | 1 | One-cycle strobe marking `byte_data` as a received byte |
| byte_data | input | 8 | Received byte |
| tgt_sel | input | 2 | Target password: 0 read, 1 write, 2 configuration |
| old_pwd | input | 64 | Currently stored password of the selected target |
| wr_done | input | 1 | Nonvolatile write has completed |
| ack | output | 1 | Acknowledge for the previous byte |
| wr_req | output | 1 | One-cycle nonvolatile write request |
| wr_tgt | output | 2 | Target of the write request |
| wr_data | output | 64 | Value to be written |
| busy | output | 1 | Write cycle in progress |

## Verification
Every result of this block comes from a register, so it appears exactly one clock edge after its cause. A byte that is valid in cycle n produces `ack` in cycle n+1, and a commit produces `wr_req`, `wr_data`, `wr_tgt` and a high `busy` in the same cycle n+1. A `wr_done` in cycle m clears `busy` in cycle m+1. The bench drives inputs on the falling edge and holds each strobe for one cycle, then samples on the next falling edge, which lies halfway through cycle n+1. A second sample one cycle later confirms that `ack` has fallen again.

// File: rtl/pwd_pkg.sv
package pwd_pkg;
  typedef enum logic [2:0] {
    ST_IDLE  = 3'd0,
    ST_CMD   = 3'd1,
    ST_OLD   = 3'd2,
    ST_NEW1  = 3'd3,
    ST_NEW2  = 3'd4,
    ST_WRITE = 3'd5
  } pw_state_e;

  localparam logic [1:0] TGT_RD  = 2'd0;
  localparam logic [1:0] TGT_WR  = 2'd1;
  localparam logic [1:0] TGT_CFG = 2'd2;

  function automatic logic tgt_valid(input logic [1:0] t);
    return (t == TGT_RD) || (t == TGT_WR) || (t == TGT_CFG);
  endfunction
endpackage

// File: rtl/pwd_old_match.sv
module pwd_old_match #(
  parameter int PW_BYTES = 8,
  parameter int BYTE_W   = 8,
  localparam int PW_W    = PW_BYTES * BYTE_W,
  localparam int CNT_W   = (PW_BYTES > 1) ? $clog2(PW_BYTES) : 1
) (
  input  logic [PW_W-1:0]   stored,
  input  logic [CNT_W-1:0]  idx,
  input  logic [BYTE_W-1:0] byte_in,
  output logic              hit
);
  // byte idx of the stored value, most significant byte first
  function automatic logic [BYTE_W-1:0] pick(input logic [PW_W-1:0] v,
                                             input logic [CNT_W-1:0] i);
    int base;
    base = (PW_BYTES - 1 - int'(i)) * BYTE_W;
    return v[base +: BYTE_W];
  endfunction

  always_comb hit = (pick(stored, idx) == byte_in);
endmodule

// File: rtl/pwd_entry_reg.sv
module pwd_entry_reg #(
  parameter int PW_W   = 64,
  parameter int BYTE_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              clr,
  input  logic              shift,
  input  logic [BYTE_W-1:0] byte_in,
  output logic [PW_W-1:0]   value
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     value <= '0;
    else if (clr)   value <= '0;
    else if (shift) value <= {value[PW_W-BYTE_W-1:0], byte_in};
  end
endmodule

// File: rtl/pwd_cmp.sv
module pwd_cmp #(
  parameter int PW_W   = 64,
  parameter int BYTE_W = 8
) (
  input  logic [PW_W-1:0]   first,
  input  logic [PW_W-1:0]   second_part,
  input  logic [BYTE_W-1:0] last_byte,
  output logic              equal
);
  // the second entry is completed by the byte now arriving
  function automatic logic [PW_W-1:0] complete(input logic [PW_W-1:0] part,
                                               input logic [BYTE_W-1:0] b);
    return {part[PW_W-BYTE_W-1:0], b};
  endfunction

  always_comb equal = (complete(second_part, last_byte) == first);
endmodule

// File: rtl/pwd_update_ctrl.sv
module pwd_update_ctrl
  import pwd_pkg::*;
#(
  parameter int PW_BYTES = 8,
  parameter int BYTE_W   = 8,
  parameter logic [7:0] CMD_CHANGE = 8'h5A,
  parameter logic [7:0] CMD_CLEAR  = 8'hA5,
  localparam int PW_W  = PW_BYTES * BYTE_W,
  localparam int CNT_W = (PW_BYTES > 1) ? $clog2(PW_BYTES) : 1,
  localparam logic [CNT_W-1:0] LAST_IDX = CNT_W'(PW_BYTES - 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic              byte_valid,
  input  logic [BYTE_W-1:0] byte_data,
  input  logic [1:0]        tgt_sel,
  input  logic [PW_W-1:0]   old_pwd,
  input  logic              wr_done,
  output logic              ack,
  output logic              wr_req,
  output logic [1:0]        wr_tgt,
  output logic [PW_W-1:0]   wr_data,
  output logic              busy
);
  pw_state_e        state;
  logic [CNT_W-1:0] cnt;
  logic             clr_q;
  logic [1:0]       tgt_q;

  // named internal events, also watched by the checker
  logic acc, last, old_hit, cmp_eq, cmd_known;
  logic ev_cmd_bad, ev_old_bad, ev_cmp_bad, ev_commit, ev_abort, ack_d;
  logic ent_clr;
  logic [1:0] ent_shift;
  logic [PW_W-1:0] ent_val [2];

  pwd_old_match #(.PW_BYTES(PW_BYTES), .BYTE_W(BYTE_W)) u_old (
    .stored (old_pwd),
    .idx    (cnt),
    .byte_in(byte_data),
    .hit    (old_hit)
  );

  for (genvar g = 0; g < 2; g++) begin : g_entry
    pwd_entry_reg #(.PW_W(PW_W), .BYTE_W(BYTE_W)) u_ent (
      .clk    (clk),
      .rst_n  (rst_n),
      .clr    (ent_clr),
      .shift  (ent_shift[g]),
      .byte_in(byte_data),
      .value  (ent_val[g])
    );
  end

  pwd_cmp #(.PW_W(PW_W), .BYTE_W(BYTE_W)) u_cmp (
    .first      (ent_val[0]),
    .second_part(ent_val[1]),
    .last_byte  (byte_data),
    .equal      (cmp_eq)
  );

  always_comb begin
    acc        = byte_valid && !start;
    last       = (cnt == LAST_IDX);
    cmd_known  = ((byte_data == CMD_CHANGE) || (byte_data == CMD_CLEAR)) && tgt_valid(tgt_sel);
    ev_cmd_bad = (state == ST_CMD)  && acc && !cmd_known;
    ev_old_bad = (state == ST_OLD)  && acc && !old_hit;
    ev_cmp_bad = (state == ST_NEW2) && acc && last && !cmp_eq;
    ev_commit  = ((state == ST_OLD)  && acc && old_hit && last && clr_q) ||
                 ((state == ST_NEW2) && acc && last && cmp_eq);
    ev_abort   = ev_cmd_bad || ev_old_bad || ev_cmp_bad;
    ack_d      = ((state == ST_CMD)  && acc && cmd_known) ||
                 ((state == ST_OLD)  && acc && old_hit) ||
                 ((state == ST_NEW1) && acc) ||
                 ((state == ST_NEW2) && acc && (!last || cmp_eq));
    ent_shift[0] = (state == ST_NEW1) && acc;
    ent_shift[1] = (state == ST_NEW2) && acc && !last;
    ent_clr      = ev_abort || ev_commit || (start && (state != ST_WRITE));
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state   <= ST_IDLE;
      cnt     <= '0;
      clr_q   <= 1'b0;
      tgt_q   <= TGT_RD;
      ack     <= 1'b0;
      wr_req  <= 1'b0;
      wr_tgt  <= TGT_RD;
      wr_data <= '0;
    end else begin
      ack    <= ack_d;
      wr_req <= ev_commit;
      if (state == ST_WRITE) begin
        if (wr_done) state <= ST_IDLE;
      end else if (start) begin
        state <= ST_CMD;
        cnt   <= '0;
      end else if (ev_abort) begin
        state <= ST_IDLE;
        cnt   <= '0;
      end else if (ev_commit) begin
        state   <= ST_WRITE;
        cnt     <= '0;
        wr_tgt  <= tgt_q;
        wr_data <= clr_q ? '0 : ent_val[0];
      end else if (acc) begin
        unique case (state)
          ST_CMD: begin
            state <= ST_OLD;
            cnt   <= '0;
            clr_q <= (byte_data == CMD_CLEAR);
            tgt_q <= tgt_sel;
          end
          ST_OLD: begin
            cnt <= last ? '0 : cnt + 1'b1;
            if (last) state <= ST_NEW1;
          end
          ST_NEW1: begin
            cnt <= last ? '0 : cnt + 1'b1;
            if (last) state <= ST_NEW2;
          end
          ST_NEW2: cnt <= cnt + 1'b1;
          default: ;
        endcase
      end
    end
  end

  always_comb busy = (state == ST_WRITE);
endmodule

// File: rtl/pwd_update_chk.sv
module pwd_update_chk (
  input logic clk,
  input logic rst_n,
  input logic byte_valid,
  input logic wr_done,
  input logic ack,
  input logic wr_req,
  input logic busy,
  input logic ev_cmd_bad,
  input logic ev_old_bad,
  input logic ev_cmp_bad
);
  a_r10_ack_follows_byte: assert property (@(posedge clk) disable iff (!rst_n)
    ack |-> $past(byte_valid));
  a_r6_req_single: assert property (@(posedge clk) disable iff (!rst_n)
    wr_req |=> !wr_req);
  a_r6_req_acked: assert property (@(posedge clk) disable iff (!rst_n)
    wr_req |-> ack);
  a_r8_busy_with_req: assert property (@(posedge clk) disable iff (!rst_n)
    wr_req |-> busy);
  a_r8_busy_holds: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !wr_done) |=> busy);
  a_r8_done_releases: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && wr_done) |=> !busy);
  a_r8_busy_no_ack: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !wr_req) |-> !ack);
  a_r2_bad_cmd_silent: assert property (@(posedge clk) disable iff (!rst_n)
    ev_cmd_bad |=> !ack);
  a_r3_bad_old_silent: assert property (@(posedge clk) disable iff (!rst_n)
    ev_old_bad |=> (!ack && !wr_req));
  a_r5_mismatch_silent: assert property (@(posedge clk) disable iff (!rst_n)
    ev_cmp_bad |=> (!ack && !wr_req));
endmodule

bind pwd_update_ctrl pwd_update_chk u_pwd_update_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .byte_valid(byte_valid),
  .wr_done   (wr_done),
  .ack       (ack),
  .wr_req    (wr_req),
  .busy      (busy),
  .ev_cmd_bad(ev_cmd_bad),
  .ev_old_bad(ev_old_bad),
  .ev_cmp_bad(ev_cmp_bad)
);

// File: tb/test_pwd_update_ctrl.sv
module test_pwd_update_ctrl;
  localparam int CLK_P = 10;
  localparam logic [7:0]  K_CHG = 8'h5A;
  localparam logic [7:0]  K_CLR = 8'hA5;
  localparam logic [63:0] STORED = 64'h0123_4567_89AB_CDEF;

  typedef struct packed {
    logic [7:0]  cmd;
    logic [1:0]  tgt;
    logic [63:0] old_in;
    logic [63:0] n1;
    logic [63:0] n2;
  } vec_t;

  localparam int NV = 8;
  localparam vec_t VECS [NV] = '{
    '{K_CHG, 2'd1, STORED, 64'hDEAD_BEEF_0BAD_F00D, 64'hDEAD_BEEF_0BAD_F00D},
    '{K_CHG, 2'd2, STORED, 64'h1111_2222_3333_4444, 64'h1111_2222_3333_4445},
    '{K_CHG, 2'd0, 64'h0123_4566_89AB_CDEF, 64'h5555_5555_5555_5555, 64'h5555_5555_5555_5555},
    '{K_CLR, 2'd2, STORED, 64'h0, 64'h0},
    '{8'h33, 2'd0, STORED, 64'h7, 64'h7},
    '{K_CHG, 2'd3, STORED, 64'h9, 64'h9},
    '{K_CHG, 2'd0, STORED, 64'hAA00_0000_0000_0001, 64'hBB00_0000_0000_0001},
    '{K_CLR, 2'd1, 64'h0123_4567_89AB_CDEE, 64'h0, 64'h0}
  };

  logic clk = 1'b0, rst_n = 1'b0, start = 1'b0, byte_valid = 1'b0, wr_done = 1'b0;
  logic [7:0]  byte_data = '0;
  logic [1:0]  tgt_sel = '0;
  logic [63:0] old_pwd = STORED;
  logic ack, wr_req, busy;
  logic [1:0]  wr_tgt;
  logic [63:0] wr_data;
  int n_chk = 0, n_bad = 0;
  bit finished = 0;

  always #(CLK_P/2) clk = ~clk;

  pwd_update_ctrl i_pwd_update_ctrl (
    .clk(clk), .rst_n(rst_n), .start(start), .byte_valid(byte_valid),
    .byte_data(byte_data), .tgt_sel(tgt_sel), .old_pwd(old_pwd),
    .wr_done(wr_done), .ack(ack), .wr_req(wr_req), .wr_tgt(wr_tgt),
    .wr_data(wr_data), .busy(busy)
  );

  task automatic chk(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic send_byte(input logic [7:0] b, output logic a, output logic r);
    @(negedge clk); byte_valid = 1'b1; byte_data = b;
    @(negedge clk); byte_valid = 1'b0; a = ack; r = wr_req;
  endtask

  task automatic pulse_start();
    @(negedge clk); start = 1'b1;
    @(negedge clk); start = 1'b0;
  endtask

  task automatic pulse_done();
    @(negedge clk); wr_done = 1'b1;
    @(negedge clk); wr_done = 1'b0;
  endtask

  function automatic logic [7:0] byte_at(input vec_t v, input int k);
    if (k == 0)  return v.cmd;
    if (k <= 8)  return v.old_in[63-8*(k-1) -: 8];
    if (k <= 16) return v.n1[63-8*(k-9) -: 8];
    return v.n2[63-8*(k-17) -: 8];
  endfunction

  // index of the first unacknowledged byte (equals frame length on success)
  function automatic int first_silent(input vec_t v);
    if (!((v.cmd == K_CHG || v.cmd == K_CLR) && v.tgt != 2'd3)) return 0;
    for (int i = 0; i < 8; i++)
      if (v.old_in[63-8*i -: 8] != STORED[63-8*i -: 8]) return 1 + i;
    if (v.cmd == K_CLR) return 9;
    if (v.n1 != v.n2) return 24;
    return 25;
  endfunction

  initial begin
    #(CLK_P * 100000);
    if (!finished) begin
      n_chk++; n_bad++;
      $display("FAIL R1 watchdog expired actual=running expected=done");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    logic a, r;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk({ack, wr_req, busy} == 3'b000, "R1 reset outputs", {61'd0, ack, wr_req, busy}, 64'd0);
    send_byte(K_CHG, a, r);
    chk(a == 1'b0, "R1 byte before start", a, 0);

    // table walk
    for (int s = 0; s < NV; s++) begin
      automatic vec_t v = VECS[s];
      automatic int total = (v.cmd == K_CLR) ? 9 : 25;
      automatic int ef = first_silent(v);
      automatic bit ok_pat = 1;
      automatic int reqs = 0;
      automatic bit good = (ef == total);
      tgt_sel = v.tgt;
      pulse_start();
      for (int k = 0; k < total; k++) begin
        send_byte(byte_at(v, k), a, r);
        if (a != (k < ef)) ok_pat = 0;
        if (r) reqs++;
      end
      chk(ok_pat, $sformatf("R2 R3 R4 R5 ack pattern vec %0d", s), 64'(ok_pat), 64'd1);
      chk(reqs == (good ? 1 : 0), $sformatf("R5 R6 R7 request count vec %0d", s), 64'(reqs), good ? 64'd1 : 64'd0);
      if (good) begin
        automatic logic [63:0] ed = (v.cmd == K_CLR) ? 64'd0 : v.n1;
        chk(wr_data == ed, $sformatf("R6 R7 write data vec %0d", s), wr_data, ed);
        chk(wr_tgt == v.tgt, $sformatf("R6 write target vec %0d", s), 64'(wr_tgt), 64'(v.tgt));
      end
      chk(busy == good, $sformatf("R8 busy after frame vec %0d", s), 64'(busy), 64'(good));
      if (good) begin
        pulse_done();
        chk(busy == 1'b0, $sformatf("R8 busy released vec %0d", s), 64'(busy), 64'd0);
      end
    end

    // busy window: bytes and start ignored
    tgt_sel = 2'd0;
    pulse_start();
    for (int k = 0; k < 9; k++) send_byte(k == 0 ? K_CLR : STORED[63-8*(k-1) -: 8], a, r);
    chk(busy == 1'b1, "R8 busy after clear", 64'(busy), 64'd1);
    send_byte(K_CHG, a, r);
    chk(a == 1'b0, "R8 no ack while busy", a, 0);
    pulse_start();
    send_byte(K_CHG, a, r);
    chk(a == 1'b0 && busy == 1'b1, "R8 start ignored while busy", {a, busy}, 2'b01);
    pulse_done();
    send_byte(K_CHG, a, r);
    chk(a == 1'b0, "R8 standby after write", a, 0);

    // restart mid-frame, target latched at command
    tgt_sel = 2'd0;
    pulse_start();
    send_byte(K_CHG, a, r);
    send_byte(STORED[63:56], a, r);
    send_byte(STORED[55:48], a, r);
    tgt_sel = 2'd2;
    pulse_start();
    send_byte(K_CLR, a, r);
    chk(a == 1'b1, "R9 restart accepts command", a, 1);
    tgt_sel = 2'd1;
    for (int k = 0; k < 8; k++) send_byte(STORED[63-8*k -: 8], a, r);
    chk(r == 1'b1 && wr_data == 64'd0, "R9 restart commits clear", {r, wr_data}, {1'b1, 64'd0});
    chk(wr_tgt == 2'd2, "R6 target latched at command", 64'(wr_tgt), 64'd2);
    pulse_done();

    // ack timing
    tgt_sel = 2'd1;
    pulse_start();
    send_byte(K_CHG, a, r);
    chk(a == 1'b1, "R10 ack one cycle after byte", a, 1);
    @(negedge clk);
    chk(ack == 1'b0, "R10 ack lasts one cycle", ack, 0);
    pulse_start();

    finished = 1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule